// File: doc/BRIEF.md
# Thermal Event Output Generator

This block turns a stream of temperature samples into a thermal event indication. Each accepted sample is compared with three limits: an upper alarm, a lower alarm and a critical limit. A limit condition becomes active when the sample goes past its limit. It becomes inactive only when the sample returns past that limit by a programmable hysteresis margin. The resulting event can work in comparator fashion, where it follows the limit conditions, or in latched fashion, where it stays set until software sends a clear pulse. A critical condition keeps the event asserted whatever clear pulses arrive.

The event is presented as an open-drain pad drive: a level and a drive-enable, shaped by the programmed polarity and the output enable. A polarity-independent status bit reports whether the event is asserted, gated by the same output enable. A shutdown control freezes the recorded temperature, so later samples neither update the readback value nor re-evaluate the limits.

Temperatures are two's-complement values in 0.25 °C counts.

Top module: `thermal_event_gen`

## Requirements
- R1: After reset the recorded temperature is 0, no limit condition and no latched event is held, so with output enable 1 and polarity 0 the status reads 0, the pad level reads 1 and the pad drive-enable reads 0.
- R2: Hysteresis code `cfg_hyst` selects a margin of 0 counts (code 0), 6 counts (code 1), 12 counts (code 2) or 24 counts (code 3).
- R3: The upper condition sets when a sample is strictly greater than `lim_hi`. Once set, it clears only when a sample is strictly less than `lim_hi` minus the margin. A sample equal to the limit leaves it unchanged.
- R4: The lower condition sets when a sample is strictly less than `lim_lo`. Once set, it clears only when a sample is strictly greater than `lim_lo` plus the margin.
- R5: With `cfg_intr` = 0 (comparator), the event equals the trigger condition one clock edge after the accepting strobe, and `clr_evt` has no effect.
- R6: With `cfg_intr` = 1 (latched), a strobe on which the trigger condition goes from inactive to active sets the event. The event stays set when the condition goes away and drops on a `clr_evt` pulse. While the condition stays active, a further strobe does not set it again.
- R7: The critical condition (sample > `lim_crit`, clears below `lim_crit` minus the margin) holds the event asserted in both modes. A `clr_evt` pulse given while it is active has no effect, including on the latched event.
- R8: With `cfg_crit_only` = 1 only the critical condition triggers an event. With 0, any of the upper, lower or critical conditions triggers it.
- R9: With output enable 1, polarity 0 gives pad level 0 with drive-enable 1 when the event is asserted, and level 1 with drive-enable 0 otherwise. Polarity 1 gives level 1 with drive-enable 0 when asserted, and level 0 with drive-enable 1 otherwise.
- R10: With output enable 0, status reads 0. The pad is released (level 1, drive-enable 0) for polarity 0 and grounded (level 0, drive-enable 1) for polarity 1.
- R11: While `cfg_halt` = 1, strobed samples change neither the recorded temperature nor any condition or event state.
- R12: Without `smp_vld`, a change of `smp_temp` changes neither the recorded temperature nor the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| smp_temp | input | 13 | Signed sample, 0.25 °C per count |
| lim_hi | input | 13 | Upper alarm limit, signed |
| lim_lo | input | 13 | Lower alarm limit, signed |
| lim_crit | input | 13 | Critical limit, signed |
| cfg_hyst | input | 2 | Hysteresis code |
| cfg_intr | input | 1 | 0 comparator, 1 latched |
| cfg_pol | input | 1 | 0 active low, 1 active high |
| cfg_oe | input | 1 | Event output enable |
| cfg_crit_only | input | 1 | Trigger on critical limit only |
| cfg_halt | input | 1 | Shutdown: freeze recorded sample |
| clr_evt | input | 1 | Clear pulse for the latched event |
| temp_held | output | 13 | Last recorded temperature |
| evt_pad_lvl | output | 1 | Level presented at the pad |
| evt_pad_oe | output | 1 | Pad drive-enable (1 pulls low) |
| evt_status | output | 1 | Polarity-independent event status |

## Verification
The bench walks each hysteresis code up to and past the release point. A wrong margin or a `<=` in place of `<` would release one count early, or hold one count too long. It sends a clear pulse in comparator mode, and again while the critical condition is active; a design that honours either would drop the event. In latched mode it strobes a second above-limit sample after a clear, which catches a latch that re-arms on the level instead of the crossing. It also toggles critical-only while a lower-alarm condition is pending, and runs polarity and enable through all four pad combinations.

// File: rtl/thermal_event_pkg.sv
package thermal_event_pkg;

   localparam int N_LIM    = 3;
   localparam int LIM_HI   = 0;
   localparam int LIM_CRIT = 1;
   localparam int LIM_LO   = 2;

   // margin in counts for a 2-bit hysteresis code: 0, step, 2*step, 4*step
   function automatic int hyst_counts(input logic [1:0] code, input int step);
      int r;
      case (code)
         2'd0:    r = 0;
         2'd1:    r = step;
         2'd2:    r = step * 2;
         default: r = step * 4;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tev_limit_cmp.sv
module tev_limit_cmp #(
   parameter int  W     = 13,
   parameter bit  ABOVE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                eval,
   input  logic [W-1:0]        sample,
   input  logic [W-1:0]        limit,
   input  logic [W+1:0]        margin,
   output logic                cond_q,
   output logic                cond_n
);
   localparam int XW = W + 2;

   logic signed [XW-1:0] s_x;
   logic signed [XW-1:0] l_x;
   logic signed [XW-1:0] m_x;
   logic                 nxt;

   assign s_x = {{2{sample[W-1]}}, sample};
   assign l_x = {{2{limit[W-1]}}, limit};
   assign m_x = margin;

   generate
      if (ABOVE) begin : g_above
         always_comb begin
            if (cond_q) nxt = !(s_x < (l_x - m_x));
            else        nxt = (s_x > l_x);
         end
      end else begin : g_below
         always_comb begin
            if (cond_q) nxt = !(s_x > (l_x + m_x));
            else        nxt = (s_x < l_x);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cond_q <= 1'b0;
      else if (eval) cond_q <= nxt;
   end

   assign cond_n = eval ? nxt : cond_q;

endmodule

// File: rtl/tev_event_core.sv
module tev_event_core
   import thermal_event_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eval,
   input  logic             intr,
   input  logic             crit_only,
   input  logic             clr,
   input  logic [N_LIM-1:0] cond_q,
   input  logic [N_LIM-1:0] cond_n,
   output logic             evt
);
   logic trig_q;
   logic trig_n;
   logic latch_q;

   assign trig_q = cond_q[LIM_CRIT] |
                   (~crit_only & (cond_q[LIM_HI] | cond_q[LIM_LO]));
   assign trig_n = cond_n[LIM_CRIT] |
                   (~crit_only & (cond_n[LIM_HI] | cond_n[LIM_LO]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          latch_q <= 1'b0;
      else if (!intr)                      latch_q <= 1'b0;
      else if (eval && trig_n && !trig_q)  latch_q <= 1'b1;
      else if (clr && !cond_q[LIM_CRIT])   latch_q <= 1'b0;
   end

   assign evt = intr ? (latch_q | cond_q[LIM_CRIT]) : trig_q;

endmodule

// File: rtl/tev_pin_drive.sv
module tev_pin_drive (
   input  logic evt,
   input  logic out_en,
   input  logic pol,
   output logic pad_lvl,
   output logic pad_oe,
   output logic status
);
   always_comb begin
      if (out_en) pad_lvl = pol ? evt : ~evt;
      else        pad_lvl = ~pol;
   end

   // open drain: only a low level is actively driven
   assign pad_oe = ~pad_lvl;
   assign status = out_en & evt;

endmodule

// File: rtl/thermal_event_gen.sv
module thermal_event_gen
   import thermal_event_pkg::*;
#(
   parameter int TEMP_W    = 13,
   parameter int HYST_STEP = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [TEMP_W-1:0] smp_temp,
   input  logic [TEMP_W-1:0] lim_hi,
   input  logic [TEMP_W-1:0] lim_lo,
   input  logic [TEMP_W-1:0] lim_crit,
   input  logic [1:0]        cfg_hyst,
   input  logic              cfg_intr,
   input  logic              cfg_pol,
   input  logic              cfg_oe,
   input  logic              cfg_crit_only,
   input  logic              cfg_halt,
   input  logic              clr_evt,
   output logic [TEMP_W-1:0] temp_held,
   output logic              evt_pad_lvl,
   output logic              evt_pad_oe,
   output logic              evt_status
);
   localparam int EXT_W = TEMP_W + 2;

   generate
      if (TEMP_W < 5 || TEMP_W > 30) begin : g_bad_width
         $error("thermal_event_gen: TEMP_W out of range");
      end
      if (HYST_STEP < 0 || HYST_STEP * 4 >= (1 << (TEMP_W - 1))) begin : g_bad_step
         $error("thermal_event_gen: HYST_STEP does not fit TEMP_W");
      end
   endgenerate

   logic             eval;
   logic [EXT_W-1:0] margin;
   logic [TEMP_W-1:0] lim_v [N_LIM];
   logic [N_LIM-1:0] lim_state;
   logic [N_LIM-1:0] lim_next;
   logic             evt;

   assign eval   = smp_vld & ~cfg_halt;
   assign margin = EXT_W'(hyst_counts(cfg_hyst, HYST_STEP));

   assign lim_v[LIM_HI]   = lim_hi;
   assign lim_v[LIM_CRIT] = lim_crit;
   assign lim_v[LIM_LO]   = lim_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    temp_held <= '0;
      else if (eval) temp_held <= smp_temp;
   end

   generate
      for (genvar g = 0; g < N_LIM; g++) begin : g_lim
         tev_limit_cmp #(
            .W     (TEMP_W),
            .ABOVE (g != LIM_LO)
         ) i_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .eval   (eval),
            .sample (smp_temp),
            .limit  (lim_v[g]),
            .margin (margin),
            .cond_q (lim_state[g]),
            .cond_n (lim_next[g])
         );
      end
   endgenerate

   tev_event_core i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .eval      (eval),
      .intr      (cfg_intr),
      .crit_only (cfg_crit_only),
      .clr       (clr_evt),
      .cond_q    (lim_state),
      .cond_n    (lim_next),
      .evt       (evt)
   );

   tev_pin_drive i_pin (
      .evt     (evt),
      .out_en  (cfg_oe),
      .pol     (cfg_pol),
      .pad_lvl (evt_pad_lvl),
      .pad_oe  (evt_pad_oe),
      .status  (evt_status)
   );

endmodule

// File: rtl/tev_checker.sv
module tev_checker #(
   parameter int TEMP_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_vld,
   input logic              cfg_halt,
   input logic              cfg_intr,
   input logic              cfg_oe,
   input logic              cfg_pol,
   input logic              clr_evt,
   input logic              crit_hold,
   input logic [TEMP_W-1:0] temp_held,
   input logic              evt_pad_lvl,
   input logic              evt_pad_oe,
   input logic              evt_status
);

   assert_halt_freezes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_halt |=> $stable(temp_held));

   assert_no_strobe_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(temp_held));

   assert_disabled_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_oe |-> !evt_status);

   assert_disabled_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_oe && !cfg_pol) |-> (evt_pad_lvl && !evt_pad_oe));

   assert_disabled_ground_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_oe && cfg_pol) |-> (!evt_pad_lvl && evt_pad_oe));

   assert_crit_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (crit_hold && cfg_oe) |-> evt_status);

   assert_level_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_oe && evt_status) |-> (evt_pad_lvl == cfg_pol));

   assert_latch_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_intr && evt_status && !clr_evt && !smp_vld)
         |=> (evt_status || !cfg_intr || !cfg_oe));

endmodule

bind thermal_event_gen tev_checker #(.TEMP_W(TEMP_W)) i_tev_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_vld     (smp_vld),
   .cfg_halt    (cfg_halt),
   .cfg_intr    (cfg_intr),
   .cfg_oe      (cfg_oe),
   .cfg_pol     (cfg_pol),
   .clr_evt     (clr_evt),
   .crit_hold   (lim_state[thermal_event_pkg::LIM_CRIT]),
   .temp_held   (temp_held),
   .evt_pad_lvl (evt_pad_lvl),
   .evt_pad_oe  (evt_pad_oe),
   .evt_status  (evt_status)
);

// File: tb/test_thermal_event_gen.sv
module test_thermal_event_gen;
   localparam int TW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_vld = 1'b0;
   logic [TW-1:0] smp_temp = '0;
   logic [TW-1:0] lim_hi = TW'(320);
   logic [TW-1:0] lim_lo = TW'(0);
   logic [TW-1:0] lim_crit = TW'(400);
   logic [1:0]    cfg_hyst = 2'd1;
   logic          cfg_intr = 1'b0;
   logic          cfg_pol = 1'b0;
   logic          cfg_oe = 1'b1;
   logic          cfg_crit_only = 1'b0;
   logic          cfg_halt = 1'b0;
   logic          clr_evt = 1'b0;
   logic [TW-1:0] temp_held;
   logic          evt_pad_lvl;
   logic          evt_pad_oe;
   logic          evt_status;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   thermal_event_gen i_thermal_event_gen (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_temp(smp_temp),
      .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_crit(lim_crit),
      .cfg_hyst(cfg_hyst), .cfg_intr(cfg_intr), .cfg_pol(cfg_pol),
      .cfg_oe(cfg_oe), .cfg_crit_only(cfg_crit_only), .cfg_halt(cfg_halt),
      .clr_evt(clr_evt), .temp_held(temp_held), .evt_pad_lvl(evt_pad_lvl),
      .evt_pad_oe(evt_pad_oe), .evt_status(evt_status)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_pin(input string req, input bit st, input bit lvl, input bit oe);
      chk(req, "status", int'(evt_status), int'(st));
      chk(req, "pad level", int'(evt_pad_lvl), int'(lvl));
      chk(req, "pad drive", int'(evt_pad_oe), int'(oe));
   endtask

   // one strobed sample; returns at the negedge after the capturing edge
   task automatic apply(input int t);
      @(negedge clk);
      smp_temp = TW'(t);
      smp_vld  = 1'b1;
      @(negedge clk);
      smp_vld  = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      clr_evt = 1'b1;
      @(negedge clk);
      clr_evt = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1", "temp in reset", int'(temp_held), 0);
      chk_pin("R1", 1'b0, 1'b1, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_pin("R1", 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_upper();
      cfg_hyst = 2'd1;
      apply(320); chk("R3", "equal limit", int'(evt_status), 0);
      apply(321); chk_pin("R3", 1'b1, 1'b0, 1'b1);
      apply(315); chk("R2", "code1 hold at 315", int'(evt_status), 1);
      apply(313); chk("R2", "code1 release at 313", int'(evt_status), 0);
      cfg_hyst = 2'd3;
      apply(321); chk("R3", "set code3", int'(evt_status), 1);
      apply(297); chk("R2", "code3 hold at 297", int'(evt_status), 1);
      apply(295); chk("R2", "code3 release at 295", int'(evt_status), 0);
      cfg_hyst = 2'd2;
      apply(321); chk("R3", "set code2", int'(evt_status), 1);
      apply(308); chk("R2", "code2 hold at 308", int'(evt_status), 1);
      apply(307); chk("R2", "code2 release at 307", int'(evt_status), 0);
      cfg_hyst = 2'd0;
      apply(321); chk("R3", "set code0", int'(evt_status), 1);
      apply(320); chk("R3", "code0 hold at limit", int'(evt_status), 1);
      apply(319); chk("R2", "code0 release at 319", int'(evt_status), 0);
      chk("R3", "recorded temp", int'(temp_held), 319);
   endtask

   task automatic t_lower();
      cfg_hyst = 2'd1;
      apply(-1); chk("R4", "set below lower", int'(evt_status), 1);
      apply(6);  chk("R4", "hold at lower+6", int'(evt_status), 1);
      apply(7);  chk("R4", "release at lower+7", int'(evt_status), 0);
   endtask

   task automatic t_strobe();
      @(negedge clk);
      smp_temp = TW'(500);
      repeat (3) @(negedge clk);
      chk("R12", "event without strobe", int'(evt_status), 0);
      chk("R12", "temp without strobe", int'(temp_held), 7);
   endtask

   task automatic t_cmp_clear();
      apply(321);
      pulse_clr();
      chk("R5", "clear in comparator", int'(evt_status), 1);
      apply(100);
      chk("R5", "follows condition", int'(evt_status), 0);
   endtask

   task automatic t_interrupt();
      cfg_intr = 1'b1;
      apply(321); chk("R6", "latched set", int'(evt_status), 1);
      apply(100); chk("R6", "stays after condition ends", int'(evt_status), 1);
      pulse_clr(); chk("R6", "cleared", int'(evt_status), 0);
      apply(321); chk("R6", "rearmed by crossing", int'(evt_status), 1);
      pulse_clr(); chk("R6", "cleared while above", int'(evt_status), 0);
      apply(322); chk("R6", "no re-set without crossing", int'(evt_status), 0);
      apply(100);
   endtask

   task automatic t_critical();
      apply(401); chk("R7", "critical set", int'(evt_status), 1);
      pulse_clr(); chk("R7", "clear during critical", int'(evt_status), 1);
      apply(100); chk("R7", "latch survived clear", int'(evt_status), 1);
      pulse_clr(); chk("R7", "clear after critical", int'(evt_status), 0);
      cfg_intr = 1'b0;
   endtask

   task automatic t_crit_only();
      cfg_crit_only = 1'b1;
      apply(350); chk("R8", "upper masked", int'(evt_status), 0);
      apply(401); chk("R8", "critical passes", int'(evt_status), 1);
      apply(-5);  chk("R8", "lower masked", int'(evt_status), 0);
      @(negedge clk);
      cfg_crit_only = 1'b0;
      #1;
      chk("R8", "lower unmasked", int'(evt_status), 1);
      apply(100);
   endtask

   task automatic t_polarity();
      cfg_pol = 1'b1;
      apply(321); chk_pin("R9", 1'b1, 1'b1, 1'b0);
      apply(100); chk_pin("R9", 1'b0, 1'b0, 1'b1);
      cfg_pol = 1'b0;
      #1;
      chk_pin("R9", 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_disable();
      apply(321);
      @(negedge clk);
      cfg_oe = 1'b0;
      #1;
      chk_pin("R10", 1'b0, 1'b1, 1'b0);
      cfg_pol = 1'b1;
      #1;
      chk_pin("R10", 1'b0, 1'b0, 1'b1);
      cfg_pol = 1'b0;
      cfg_oe  = 1'b1;
      #1;
      chk_pin("R10", 1'b1, 1'b0, 1'b1);
      apply(100);
   endtask

   task automatic t_shutdown();
      cfg_halt = 1'b1;
      apply(401);
      chk("R11", "temp frozen", int'(temp_held), 100);
      chk("R11", "event frozen", int'(evt_status), 0);
      cfg_halt = 1'b0;
      apply(401);
      chk("R11", "temp after resume", int'(temp_held), 401);
      chk("R11", "event after resume", int'(evt_status), 1);
      apply(100);
   endtask

   initial begin
      t_reset();
      t_upper();
      t_lower();
      t_strobe();
      t_cmp_clear();
      t_interrupt();
      t_critical();
      t_crit_only();
      t_polarity();
      t_disable();
      t_shutdown();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule